// File: doc/BRIEF.md
# Destructive-Read Word Memory Cycle Controller

This block sequences accesses to a word-wide storage array in which sensing a word wipes it. The array sits inside the block and is built from ordinary flip-flops. Each bit position of the word lives in its own plane, so a word is sensed or written all at once. When the array senses a word, it returns the stored bits and leaves every bit of that word at zero. For this reason the controller never offers a bare read. Every host command runs as one fixed-length cycle. The cycle is a sense phase followed by a restore phase at the same address.

A host issues one of three operations over a valid/ready handshake: read, write, or read-and-increment. The first two words are explained by their names; the third uses the modify stage between the two phases.
- A read senses the word, returns it, and restores it.
- A write still runs the sense phase and discards what it senses, then stores the host data.
- A read-and-increment returns the old word and restores that word plus one, modulo 2^WIDTH, all within the same cycle.

The restore phase works on a word that it takes to be all zero. A bit that must become 1 is driven. A bit that must stay 0 has its inhibit asserted. The phase lengths are parameters, and the total cycle time is their sum. A debug input can suppress the restore for one command so that a test can show the destructive effect of sensing.

Top module: `drm_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, and every word reads as zero.
- R2: A command is accepted on a clock edge where req_valid and req_ready are both 1. req_ready then stays 0 for exactly READ_CYCLES+WRITE_CYCLES clocks and returns to 1.
- R3: For read, read-and-increment and the spare code, rsp_valid is high for exactly one clock, starting READ_CYCLES clocks after the accepting edge. A write never raises rsp_valid.
- R4: A read returns the stored word and restores it, so a second read of the same address returns the same word.
- R5: A write (req_op = 1) stores req_wdata exactly, whatever the old content was. Bits that were 1 and are now 0 end up 0.
- R6: Read-and-increment (req_op = 2) returns the old word on rsp_data and leaves old+1 modulo 2^WIDTH in the array. Incrementing all-ones therefore gives zero.
- R7: A command accepted with dbg_skip_wb = 1 performs no restore. A read still returns the old word, but the word is left all zero afterwards.
- R8: The spare operation code req_op = 3 behaves exactly as a read (req_op = 0).
- R9: While req_ready is 0, req_valid and the request fields are ignored. No command is taken, no extra response appears, and no word changes.
- R10: A cycle changes only the word at its own address; every other word keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host command present |
| req_ready | output | 1 | Controller idle, command will be taken |
| req_op | input | 2 | 0 read, 1 write, 2 read-and-increment, 3 treated as read |
| req_addr | input | AW | Word address, AW = clog2(DEPTH) |
| req_wdata | input | WIDTH | Data for a write |
| dbg_skip_wb | input | 1 | Suppress the restore phase of this command |
| rsp_valid | output | 1 | One-clock strobe: rsp_data holds the sensed word |
| rsp_data | output | WIDTH | Word sensed in the last sense phase |

## Verification
The bench builds the block with WIDTH = 8, DEPTH = 8, READ_CYCLES = 3 and WRITE_CYCLES = 2. The two phases therefore differ in length, and a misplaced phase boundary shifts the response strobe or the busy window by a countable number of clocks. An 8-bit word makes the all-ones-to-zero wrap of read-and-increment reachable with a single write. Eight words are enough to show that a cycle leaves its neighbours untouched.

// File: rtl/drm_pkg.sv
package drm_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_INCR  = 2'd2,
        OP_SPARE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SENSE   = 2'd1,
        PH_RESTORE = 2'd2
    } phase_e;

    // The spare code is folded onto a plain read.
    function automatic op_e decode_op(logic [1:0] raw);
        op_e o;
        o = op_e'(raw);
        if (o == OP_SPARE) o = OP_READ;
        return o;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/drm_seq.sv
module drm_seq
    import drm_pkg::*;
#(
    parameter int unsigned READ_CYCLES  = 3,
    parameter int unsigned WRITE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic ready,
    output logic sense_fire,
    output logic restore_fire
);
    localparam int unsigned CW = $clog2(max2(READ_CYCLES, WRITE_CYCLES) + 1);
    localparam logic [CW-1:0] SENSE_LAST   = CW'(READ_CYCLES - 1);
    localparam logic [CW-1:0] RESTORE_LAST = CW'(WRITE_CYCLES - 1);

    phase_e        phase;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_SENSE;
                        cnt   <= '0;
                    end
                end
                PH_SENSE: begin
                    if (cnt == SENSE_LAST) begin
                        phase <= PH_RESTORE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_RESTORE: begin
                    if (cnt == RESTORE_LAST) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign ready        = (phase == PH_IDLE);
    assign sense_fire   = (phase == PH_SENSE)   && (cnt == SENSE_LAST);
    assign restore_fire = (phase == PH_RESTORE) && (cnt == RESTORE_LAST);

    // R2
    sense_len_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SENSE) |-> (cnt < CW'(READ_CYCLES)));

    // R2
    restore_len_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RESTORE) |-> (cnt < CW'(WRITE_CYCLES)));

    // R2
    restore_follows_sense_chk: assert property (@(posedge clk) disable iff (rst)
        sense_fire |=> (phase == PH_RESTORE));

endmodule

// File: rtl/drm_array.sv
module drm_array #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_fire,
    input  logic             wr_fire,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] inhibit,
    output logic [WIDTH-1:0] sense_q
);
    // One plane per bit of the word; all planes act on the same address.
    for (genvar b = 0; b < WIDTH; b++) begin : g_plane
        logic [DEPTH-1:0] cells;
        logic             sense_bit;

        always_ff @(posedge clk) begin
            if (rst) begin
                cells     <= '0;
                sense_bit <= 1'b0;
            end else if (rd_fire) begin
                sense_bit   <= cells[addr];
                cells[addr] <= 1'b0;
            end else if (wr_fire) begin
                // The word is taken to be zero: drive a 1 unless inhibited.
                if (!inhibit[b]) cells[addr] <= 1'b1;
            end
        end

        assign sense_q[b] = sense_bit;

        // R4
        wb_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
            wr_fire |-> (cells[addr] == 1'b0));

        // R7
        sense_clears_chk: assert property (@(posedge clk) disable iff (rst)
            rd_fire |=> (cells[$past(addr)] == 1'b0));
    end

    // R2
    phases_apart_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_fire && wr_fire));

endmodule

// File: rtl/drm_modify.sv
module drm_modify
    import drm_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] sensed,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] wb_word
);
    always_comb begin
        unique case (op)
            OP_WRITE: wb_word = wdata;
            OP_INCR:  wb_word = sensed + WIDTH'(1);
            default:  wb_word = sensed;
        endcase
    end
endmodule

// File: rtl/drm_ctrl.sv
module drm_ctrl
    import drm_pkg::*;
#(
    parameter int unsigned WIDTH        = 8,
    parameter int unsigned DEPTH        = 16,
    parameter int unsigned READ_CYCLES  = 3,
    parameter int unsigned WRITE_CYCLES = 2,
    localparam int unsigned AW          = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [AW-1:0]    req_addr,
    input  logic [WIDTH-1:0] req_wdata,
    input  logic             dbg_skip_wb,
    output logic             rsp_valid,
    output logic [WIDTH-1:0] rsp_data
);
    typedef struct packed {
        op_e              op;
        logic [AW-1:0]    addr;
        logic [WIDTH-1:0] wdata;
        logic             skip;
    } cmd_t;

    cmd_t             cmd_q;
    logic             accept;
    logic             sense_fire;
    logic             restore_fire;
    logic [WIDTH-1:0] sensed;
    logic [WIDTH-1:0] wb_word;

    assign accept = req_valid && req_ready;

    drm_seq #(
        .READ_CYCLES (READ_CYCLES),
        .WRITE_CYCLES(WRITE_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .ready       (req_ready),
        .sense_fire  (sense_fire),
        .restore_fire(restore_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= '0;
            rsp_valid <= 1'b0;
        end else begin
            if (accept) begin
                cmd_q.op    <= decode_op(req_op);
                cmd_q.addr  <= req_addr;
                cmd_q.wdata <= req_wdata;
                cmd_q.skip  <= dbg_skip_wb;
            end
            rsp_valid <= sense_fire && (cmd_q.op != OP_WRITE);
        end
    end

    drm_array #(
        .WIDTH(WIDTH),
        .DEPTH(DEPTH)
    ) u_array (
        .clk    (clk),
        .rst    (rst),
        .rd_fire(sense_fire),
        .wr_fire(restore_fire && !cmd_q.skip),
        .addr   (cmd_q.addr),
        .inhibit(~wb_word),
        .sense_q(sensed)
    );

    drm_modify #(
        .WIDTH(WIDTH)
    ) u_modify (
        .op     (cmd_q.op),
        .sensed (sensed),
        .wdata  (cmd_q.wdata),
        .wb_word(wb_word)
    );

    assign rsp_data = sensed;

    // R3
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

    // R3
    rsp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (cmd_q.op != OP_WRITE));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> $stable(cmd_q));

endmodule

// File: tb/tb_drm_ctrl.sv
`timescale 1ns/1ps
module tb_drm_ctrl;
    localparam int W  = 8;
    localparam int D  = 8;
    localparam int RC = 3;
    localparam int WC = 2;
    localparam int AW = $clog2(D);

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic          req_ready;
    logic [1:0]    req_op;
    logic [AW-1:0] req_addr;
    logic [W-1:0]  req_wdata;
    logic          dbg_skip_wb;
    logic          rsp_valid;
    logic [W-1:0]  rsp_data;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    drm_ctrl #(.WIDTH(W), .DEPTH(D), .READ_CYCLES(RC), .WRITE_CYCLES(WC)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .dbg_skip_wb(dbg_skip_wb), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one command; with jam set, a conflicting write is held on the port while busy.
    task automatic run(input logic [1:0] op, input logic [AW-1:0] a, input logic [W-1:0] wd,
                       input bit skip, input bit jam,
                       output logic [W-1:0] data, output int nrsp, output int rsp_at,
                       output int busy);
        nrsp = 0; rsp_at = 0; busy = 0; data = '0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 idle before command", int'(req_ready), 1);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd; dbg_skip_wb = skip;
        @(negedge clk);
        req_valid = 1'b0; dbg_skip_wb = 1'b0;
        for (int k = 1; k < 64; k++) begin
            if (req_ready) break;
            if (jam) begin
                req_valid = (k < RC + WC);
                req_op = 2'd1; req_addr = 3'd4; req_wdata = 8'hEE;
            end
            if (rsp_valid) begin
                nrsp++; rsp_at = k; data = rsp_data;
            end
            busy++;
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] data);
        int n, at, b;
        run(2'd0, a, '0, 0, 0, data, n, at, b);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] wd);
        logic [W-1:0] d;
        int n, at, b;
        run(2'd1, a, wd, 0, 0, d, n, at, b);
    endtask

    task automatic t_reset;
        logic [W-1:0] d;
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);
        for (int a = 0; a < D; a++) begin
            rd(AW'(a), d);
            chk(d == '0, "R1 word zero after reset", int'(d), 0);
        end
    endtask

    task automatic t_write_read;
        logic [W-1:0] d;
        int n, at, b;
        run(2'd1, 3'd3, 8'hA5, 0, 0, d, n, at, b);
        chk(b == RC + WC, "R2 busy length on write", b, RC + WC);
        chk(n == 0, "R3 write gives no response", n, 0);
        run(2'd0, 3'd3, '0, 0, 0, d, n, at, b);
        chk(d == 8'hA5, "R4 read returns stored word", int'(d), 'hA5);
        chk(n == 1, "R3 single response on read", n, 1);
        chk(at == RC + 1, "R3 response timing", at, RC + 1);
        chk(b == RC + WC, "R2 busy length on read", b, RC + WC);
        rd(3'd3, d);
        chk(d == 8'hA5, "R4 word restored after read", int'(d), 'hA5);
    endtask

    task automatic t_overwrite;
        logic [W-1:0] d;
        wr(3'd3, 8'h0F);
        rd(3'd3, d);
        chk(d == 8'h0F, "R5 write replaces old ones", int'(d), 'h0F);
    endtask

    task automatic t_incr;
        logic [W-1:0] d;
        int n, at, b;
        wr(3'd5, 8'h41);
        run(2'd2, 3'd5, '0, 0, 0, d, n, at, b);
        chk(d == 8'h41, "R6 increment returns old word", int'(d), 'h41);
        chk(n == 1 && at == RC + 1, "R3 increment response timing", at, RC + 1);
        chk(b == RC + WC, "R2 increment single cycle", b, RC + WC);
        rd(3'd5, d);
        chk(d == 8'h42, "R6 incremented word stored", int'(d), 'h42);
        wr(3'd6, 8'hFF);
        run(2'd2, 3'd6, '0, 0, 0, d, n, at, b);
        chk(d == 8'hFF, "R6 wrap returns old word", int'(d), 'hFF);
        rd(3'd6, d);
        chk(d == 8'h00, "R6 increment wraps to zero", int'(d), 0);
    endtask

    task automatic t_skip;
        logic [W-1:0] d;
        int n, at, b;
        wr(3'd2, 8'h3C);
        run(2'd0, 3'd2, '0, 1, 0, d, n, at, b);
        chk(d == 8'h3C, "R7 skipped restore still returns word", int'(d), 'h3C);
        rd(3'd2, d);
        chk(d == 8'h00, "R7 skipped restore leaves zero", int'(d), 0);
    endtask

    task automatic t_spare;
        logic [W-1:0] d;
        int n, at, b;
        wr(3'd1, 8'h99);
        run(2'd3, 3'd1, 8'h55, 0, 0, d, n, at, b);
        chk(d == 8'h99 && n == 1, "R8 spare code reads", int'(d), 'h99);
        rd(3'd1, d);
        chk(d == 8'h99, "R8 spare code restores", int'(d), 'h99);
    endtask

    task automatic t_busy_ignore;
        logic [W-1:0] d;
        int n, at, b;
        wr(3'd4, 8'h11);
        wr(3'd0, 8'h77);
        run(2'd0, 3'd0, '0, 0, 1, d, n, at, b);
        chk(n == 1, "R9 no extra response while busy", n, 1);
        chk(b == RC + WC, "R9 busy window unchanged", b, RC + WC);
        chk(d == 8'h77, "R9 read unaffected by held request", int'(d), 'h77);
        rd(3'd4, d);
        chk(d == 8'h11, "R9 held write not taken", int'(d), 'h11);
    endtask

    task automatic t_neighbours;
        logic [W-1:0] d;
        rd(3'd7, d);
        chk(d == 8'h00, "R10 untouched word stays zero", int'(d), 0);
        rd(3'd3, d);
        chk(d == 8'h0F, "R10 neighbour keeps value", int'(d), 'h0F);
        rd(3'd1, d);
        chk(d == 8'h99, "R10 neighbour keeps value", int'(d), 'h99);
        rd(3'd5, d);
        chk(d == 8'h42, "R10 neighbour keeps value", int'(d), 'h42);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_op = '0; req_addr = '0;
        req_wdata = '0; dbg_skip_wb = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_overwrite();
        t_incr();
        t_skip();
        t_spare();
        t_busy_ignore();
        t_neighbours();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule